// File: doc/BRIEF.md
# Quadword-to-Word Memory Write Bridge

This block sits between a streaming producer of 128-bit quadwords and a memory map that accepts 32-bit addressed writes. Each quadword taken from a valid/ready stream is held internally and issued as four back-to-back word writes, lowest lane first. Each write carries a byte enable and a fixed initiator tag, so that downstream logging and arbitration can tell who wrote.

Addresses come from a pointer that starts at a destination base set by a parameter. The pointer moves by one word per write and keeps counting across quadwords of the same transfer. When the quadword carrying the end-of-transfer marker has been fully written, the pointer goes back to the base for the next transfer. The stream is held off while a quadword is being serialised, so the producer never needs its own buffer.

Top module: `qw_write_bridge`

## Requirements
- R1: After reset the write enable is low and the input ready is high, with the address pointer at the base.
- R2: Each accepted quadword yields exactly four writes, on four consecutive clock cycles, with the first in the cycle after acceptance.
- R3: Word order is little-endian: the writes carry bits [31:0], [63:32], [95:64] and [127:96] of the quadword, in that order.
- R4: The first write of a transfer targets the base address (default 0x400). Each following write targets the previous address plus 4, including across quadword boundaries within one transfer.
- R5: Every write carries the master identifier parameter (default 3) and a byte enable of 4'b1111.
- R6: Input ready is low from the cycle after a quadword is accepted until its fourth word has been issued. Input valid and data presented during that time are ignored and change no write.
- R7: After the fourth write of a quadword accepted with the last marker high, the next transfer starts again at the base address.
- R8: No word is lost or repeated: the total number of writes equals four times the number of accepted quadwords.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Quadword offered |
| in_data | input | 128 | Quadword payload |
| in_last | input | 1 | Quadword ends the transfer |
| in_ready | output | 1 | Bridge can take a quadword |
| wr_en | output | 1 | Word write strobe |
| wr_addr | output | 32 | Word write address |
| wr_data | output | 32 | Word write data |
| wr_be | output | 4 | Byte enable, always all ones |
| wr_master_id | output | 8 | Initiator tag on each write |

## Verification
The hardest case to reach is a producer that keeps offering new payload while the bridge is still draining a quadword. If that offer slips in, a word is corrupted or duplicated, and nothing shows until the address sequence is compared. The stimulus accepts one quadword, then raises valid with different data during the busy window and drops it before the window closes. It checks ready in each of those cycles and then confirms that only the original four words appeared. A second hard case is a transfer split by idle gaps. It is reached by sending a non-last quadword, idling, then sending the last one, and checking that addresses continue and then wrap to the base.

// File: rtl/qwb_pkg.sv
package qwb_pkg;
  parameter int unsigned QWB_IN_W   = 128;
  parameter int unsigned QWB_WORD_W = 32;

  function automatic int unsigned qwb_lanes(input int unsigned in_w, input int unsigned word_w);
    return in_w / word_w;
  endfunction

  function automatic int unsigned qwb_idx_w(input int unsigned lanes);
    return (lanes > 1) ? $clog2(lanes) : 1;
  endfunction
endpackage

// File: rtl/qwb_lane_seq.sv
module qwb_lane_seq #(
  parameter int unsigned IN_W   = qwb_pkg::QWB_IN_W,
  parameter int unsigned WORD_W = qwb_pkg::QWB_WORD_W,
  localparam int unsigned LANES = qwb_pkg::qwb_lanes(IN_W, WORD_W),
  localparam int unsigned IDX_W = qwb_pkg::qwb_idx_w(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [IN_W-1:0]   in_data,
  input  logic              in_last,
  output logic              in_ready,
  output logic              word_vld,
  output logic [WORD_W-1:0] word_data,
  output logic              word_final,
  output logic              xfer_end
);
  localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(LANES - 1);

  logic              busy_q, busy_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [IN_W-1:0]   hold_q, hold_d;
  logic              last_q, last_d;
  logic              take;
  logic [WORD_W-1:0] lane [LANES];

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      assign lane[g] = hold_q[g*WORD_W +: WORD_W];
    end
  endgenerate

  assign in_ready   = !busy_q;
  assign take       = in_valid && !busy_q;
  assign word_vld   = busy_q;
  assign word_data  = lane[idx_q];
  assign word_final = busy_q && (idx_q == IDX_TOP);
  assign xfer_end   = last_q;

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    hold_d = hold_q;
    last_d = last_q;
    if (take) begin
      busy_d = 1'b1;
      idx_d  = '0;
      hold_d = in_data;
      last_d = in_last;
    end else if (busy_q) begin
      if (idx_q == IDX_TOP) begin
        busy_d = 1'b0;
        idx_d  = '0;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      last_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      last_q <= last_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else if (take) hold_q <= hold_d;
  end

  // R2: a started quadword keeps issuing words until its final lane
  a_r2_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld && !word_final) |=> word_vld);

  // R2: acceptance is followed by a write in the next cycle
  a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (word_vld && !in_ready));

  // R6: payload held during serialisation does not move
  a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld && !word_final) |=> $stable(hold_q));
endmodule

// File: rtl/qwb_addr_ptr.sv
module qwb_addr_ptr #(
  parameter int unsigned  ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE = '0,
  parameter int unsigned  STEP   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic              wrap_en,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

  logic [ADDR_W-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (wrap_en)      ptr_d = BASE;
    else if (step_en) ptr_d = ptr_q + STEP_V;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= BASE;
    else        ptr_q <= ptr_d;
  end

  assign addr = ptr_q;

  // R7: finishing the last quadword returns the pointer to the base
  a_r7_wrap_base: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_en |=> (addr == BASE));

  // R4: an idle cycle leaves the pointer alone
  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_en && !wrap_en) |=> $stable(addr));
endmodule

// File: rtl/qw_write_bridge.sv
module qw_write_bridge #(
  parameter int unsigned IN_W      = qwb_pkg::QWB_IN_W,
  parameter int unsigned WORD_W    = qwb_pkg::QWB_WORD_W,
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned ID_W      = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h0000_0400,
  parameter logic [ID_W-1:0]   MASTER_ID = 8'd3,
  localparam int unsigned BE_W   = WORD_W / 8,
  localparam int unsigned STEP   = WORD_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [IN_W-1:0]   in_data,
  input  logic              in_last,
  output logic              in_ready,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic [BE_W-1:0]   wr_be,
  output logic [ID_W-1:0]   wr_master_id
);
  logic word_vld;
  logic word_final;
  logic xfer_end;

  qwb_lane_seq #(.IN_W(IN_W), .WORD_W(WORD_W)) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .in_last    (in_last),
    .in_ready   (in_ready),
    .word_vld   (word_vld),
    .word_data  (wr_data),
    .word_final (word_final),
    .xfer_end   (xfer_end)
  );

  qwb_addr_ptr #(.ADDR_W(ADDR_W), .BASE(BASE_ADDR), .STEP(STEP)) ptr_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_en (word_vld),
    .wrap_en (word_final && xfer_end),
    .addr    (wr_addr)
  );

  assign wr_en        = word_vld;
  assign wr_be        = '1;
  assign wr_master_id = MASTER_ID;

  // R4: back-to-back writes step by one word
  a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en ##1 wr_en) |-> (wr_addr == $past(wr_addr) + ADDR_W'(STEP)));

  // R6: no new quadword can be taken while writes are in flight
  a_r6_busy_block: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !word_final) |=> !in_ready);
endmodule

// File: tb/qw_write_bridge_tb_top.sv
`timescale 1ns/1ps
module qw_write_bridge_tb_top;
  localparam logic [31:0] BASE = 32'h0000_0400;

  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic [127:0] in_data;
  logic         in_last;
  logic         in_ready;
  logic         wr_en;
  logic [31:0]  wr_addr;
  logic [31:0]  wr_data;
  logic [3:0]   wr_be;
  logic [7:0]   wr_master_id;

  qw_write_bridge dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_ready(in_ready), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_be(wr_be), .wr_master_id(wr_master_id)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int nlog   = 0;
  int accepted = 0;
  logic [31:0] log_addr [64];
  logic [31:0] log_data [64];
  logic [3:0]  log_be   [64];
  logic [7:0]  log_id   [64];
  int          log_cyc  [64];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && wr_en && nlog < 64) begin
      log_addr[nlog] = wr_addr;
      log_data[nlog] = wr_data;
      log_be[nlog]   = wr_be;
      log_id[nlog]   = wr_master_id;
      log_cyc[nlog]  = cyc;
      nlog = nlog + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_qw(input logic [127:0] d, input logic lst);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_last = lst;
    while (!in_ready) @(negedge clk);
    accepted++;
    @(negedge clk);
    in_valid = 1'b0; in_data = '0; in_last = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // checks nq quadwords logged from index first, address word offset off
  task automatic check_run(input int first, input logic [127:0] q [], input int off);
    for (int k = 0; k < 4*q.size(); k++) begin
      logic [31:0] ea, ed;
      ea = BASE + 32'(4*(off+k));
      ed = q[k/4][32*(k%4) +: 32];
      chk(log_addr[first+k] == ea, "R4 address", 64'(log_addr[first+k]), 64'(ea));
      chk(log_data[first+k] == ed, "R3 lane order", 64'(log_data[first+k]), 64'(ed));
      chk(log_be[first+k] == 4'hF && log_id[first+k] == 8'd3, "R5 be/master id",
          {52'd0, log_be[first+k], log_id[first+k]}, 64'hF03);
      if (k%4 != 0)
        chk(log_cyc[first+k] == log_cyc[first+k-1] + 1, "R2 consecutive cycles",
            64'(log_cyc[first+k]), 64'(log_cyc[first+k-1] + 1));
    end
  endtask

  task automatic t_reset;
    chk(wr_en == 1'b0, "R1 write enable low", 64'(wr_en), 64'd0);
    chk(in_ready == 1'b1, "R1 ready high", 64'(in_ready), 64'd1);
  endtask

  task automatic t_single;
    int s;
    logic [127:0] q [] = '{128'hDDDD_DDDD_CCCC_CCCC_BBBB_BBBB_AAAA_AAAA};
    s = nlog;
    send_qw(q[0], 1'b1);
    idle(6);
    chk(nlog - s == 4, "R2 four writes", 64'(nlog - s), 64'd4);
    check_run(s, q, 0);
  endtask

  task automatic t_stream;
    int s;
    logic [127:0] q [] = '{128'h4444_4444_3333_3333_2222_2222_1111_1111,
                           128'h8888_8888_7777_7777_6666_6666_5555_5555};
    s = nlog;
    send_qw(q[0], 1'b0);
    send_qw(q[1], 1'b1);
    idle(6);
    chk(nlog - s == 8, "R8 eight writes for two quadwords", 64'(nlog - s), 64'd8);
    check_run(s, q, 0);
  endtask

  task automatic t_busy_ignore;
    int s;
    logic [127:0] q [] = '{128'h0F0E0D0C_0B0A0908_07060504_03020100};
    s = nlog;
    send_qw(q[0], 1'b1);
    chk(in_ready == 1'b0, "R6 ready low word0", 64'(in_ready), 64'd0);
    in_data = {4{32'hDEAD_BEEF}};
    @(negedge clk);
    in_valid = 1'b1;
    chk(in_ready == 1'b0, "R6 ready low word1", 64'(in_ready), 64'd0);
    @(negedge clk);
    chk(in_ready == 1'b0, "R6 ready low word2", 64'(in_ready), 64'd0);
    @(negedge clk);
    in_valid = 1'b0;
    chk(in_ready == 1'b0, "R6 ready low word3", 64'(in_ready), 64'd0);
    @(negedge clk);
    chk(in_ready == 1'b1, "R6 ready back after word3", 64'(in_ready), 64'd1);
    in_data = '0;
    idle(6);
    chk(nlog - s == 4, "R6 busy offer ignored", 64'(nlog - s), 64'd4);
    check_run(s, q, 0);
  endtask

  task automatic t_gap_and_wrap;
    int s;
    logic [127:0] a [] = '{128'hA3A3A3A3_A2A2A2A2_A1A1A1A1_A0A0A0A0};
    logic [127:0] b [] = '{128'hB3B3B3B3_B2B2B2B2_B1B1B1B1_B0B0B0B0};
    logic [127:0] c [] = '{128'hC3C3C3C3_C2C2C2C2_C1C1C1C1_C0C0C0C0};
    s = nlog;
    send_qw(a[0], 1'b0);
    idle(9);
    send_qw(b[0], 1'b1);
    idle(6);
    check_run(s, a, 0);
    check_run(s + 4, b, 4);
    send_qw(c[0], 1'b1);
    idle(6);
    chk(log_addr[s+8] == BASE, "R7 next transfer at base", 64'(log_addr[s+8]), 64'(BASE));
    check_run(s + 8, c, 0);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_last = 1'b0;
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_single();
    t_stream();
    t_busy_ignore();
    t_gap_and_wrap();
    chk(nlog == 4*accepted, "R8 total writes", 64'(nlog), 64'(4*accepted));
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule